// File: doc/BRIEF.md
# NAND Cache-Read Command Sequencer

This block sits on the host side of an 8-bit NAND flash bus. It reads a run of pages through the device's cache register. A run opens with an ordinary page read to a chosen row. After that the host can ask for the next page in order, jump to any row, or close the run. Each of these requests turns into the matching command and address cycles on the flash bus. Command bytes go out with CLE high and address bytes with ALE high, and each is strobed by WE#. The block then waits on the ready/busy line and reads the page out one byte per RE# pulse.

Read bytes leave through a valid/ready stream, which flags the final byte of the page and the bytes of the spare area. The host may also move the read column inside the page that is currently held. Inside a run, the block ignores requests that would break the cache-read rules, and for most of them it raises no signal. The exception is a sequential step past the last row of the device: the block refuses it and raises an error pulse. If ready/busy stays low for longer than a parameterised number of cycles, the block abandons the run and raises a timeout pulse.

Top module: `nand_cache_rd_seq`

## Requirements
- R1: While reset is asserted and after it is released: WE# and RE# are high, CLE, ALE, the data-bus drive enable and out_valid are low, and req_ready is high.
- R2: The start request (req_op=0) is sent as the following byte cycles, in order. Command 00h, strobed by WE# with CLE high. Two column address bytes, both 00h. Three row address bytes, least significant first. Command 30h. Each address byte is strobed by WE# with ALE high, and CLE and ALE are never high together.
- R3: After any confirm command (30h, 31h or the exit code), no WE# or RE# strobe occurs while ready/busy is low. The next phase starts only after ready/busy has been seen high, and no earlier than WB_CYC cycles after the confirm.
- R4: The next-page request (req_op=1) issues the single command 31h. After ready/busy returns high, it streams PAGE_BYTES bytes from column 0, and out_last is high on the final byte only.
- R5: The jump request (req_op=2) issues command 00h, then column bytes 00h and 00h, then the three bytes of the requested row, then command 31h. It then streams a whole page from column 0.
- R6: out_spare is high exactly on the streamed bytes whose column is MAIN_BYTES or above.
- R7: No byte is read from the flash or streamed out until a cache-read command (31h or the exit code) has been issued in the run. A start request streams nothing. A column request (req_op=4) made before the first cache-read command causes no bus cycle.
- R8: The finish request (req_op=3) issues the exit command EXIT_CMD (default 3Fh), streams the final page from column 0 and ends the run. A later next-page request causes no bus cycle.
- R9: A next-page request made when the row last loaded equals LAST_ROW causes no bus cycle. Instead, err_lastpage pulses high for one cycle.
- R10: The column request issues command 05h, then the low and high bytes of req_col with ALE high, then command E0h. It then streams bytes from column req_col through the end of the page, without waiting on ready/busy.
- R11: While out_valid is high and out_ready is low, RE# stays high, and out_valid and out_data hold their values.
- R12: If ready/busy stays low for BUSY_MAX cycles after a confirm, err_timeout pulses for one cycle and the run is abandoned. req_ready returns high, and a following next-page request causes no bus cycle.
- R13: Each streamed byte equals the value on the flash data bus at the rising edge of its RE# pulse, and the block never drives the data bus while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | 0 start, 1 next page, 2 jump, 3 finish, 4 column change |
| req_row | input | ROW_W | Row for start and jump |
| req_col | input | COL_W | Column for column change |
| out_valid | output | 1 | Streamed byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Streamed byte |
| out_last | output | 1 | Byte is the last column of the page |
| out_spare | output | 1 | Byte lies in the spare area |
| err_lastpage | output | 1 | Pulse: sequential step past the last row refused |
| err_timeout | output | 1 | Pulse: ready/busy stayed low too long |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data bus value driven by the block |
| nf_dq_oe | output | 1 | Data bus drive enable |
| nf_dq_i | input | 8 | Data bus value from the flash |
| nf_rb | input | 1 | Ready/busy, low while busy |

## Verification
The assertions assume a few things about the flash. Ready/busy is synchronous to clk. It falls within WB_CYC cycles of a confirm command, so a high level seen after that window means the operation is finished. The flash data bus is steady through the last low cycle of each RE# pulse. The bench's flash model lowers ready/busy two cycles after the confirm strobe and changes it only on falling clock edges. It presents the next byte only after an RE# rising edge. The bench holds req_op to the five defined codes and keeps out_ready low except while it is collecting a page.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_NEXT   = 3'd1,
    OP_JUMP   = 3'd2,
    OP_FINISH = 3'd3,
    OP_COLUMN = 3'd4
  } nfc_op_e;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_READ = 2'd2
  } bus_kind_e;

  localparam logic [7:0] CMD_PAGE_RD  = 8'h00;
  localparam logic [7:0] CMD_PAGE_GO  = 8'h30;
  localparam logic [7:0] CMD_CACHE_GO = 8'h31;
  localparam logic [7:0] CMD_COL_SET  = 8'h05;
  localparam logic [7:0] CMD_COL_GO   = 8'hE0;
endpackage

// File: rtl/nfc_bus_phy.sv
`timescale 1ns/1ps
module nfc_bus_phy
  import nfc_pkg::*;
#(
  parameter int STB_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  bus_kind_e  kind,
  input  logic [7:0] wbyte,
  output logic       done,
  output logic [7:0] rbyte,
  output logic       nf_cle,
  output logic       nf_ale,
  output logic       nf_we_n,
  output logic       nf_re_n,
  output logic [7:0] nf_dq_o,
  output logic       nf_dq_oe,
  input  logic [7:0] nf_dq_i
);
  localparam int CNT_W = $clog2(STB_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STB_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

  ph_e              ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  bus_kind_e        kind_q;
  logic [7:0]       byte_q, rbyte_q;
  logic             done_q, done_d, load, cap;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    load   = 1'b0;
    cap    = 1'b0;
    case (ph_q)
      PH_IDLE: if (go) begin
        ph_d  = PH_LOW;
        cnt_d = '0;
        load  = 1'b1;
      end
      PH_LOW: if (cnt_q == CNT_END) begin
        ph_d  = PH_HIGH;
        cnt_d = '0;
        cap   = (kind_q == BK_READ);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      PH_HIGH: if (cnt_q == CNT_END) begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      kind_q  <= BK_CMD;
      byte_q  <= '0;
      rbyte_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (load) begin
        kind_q <= kind;
        byte_q <= wbyte;
      end
      if (cap) rbyte_q <= nf_dq_i;
    end
  end

  assign done     = done_q;
  assign rbyte    = rbyte_q;
  assign nf_cle   = (ph_q != PH_IDLE) && (kind_q == BK_CMD);
  assign nf_ale   = (ph_q != PH_IDLE) && (kind_q == BK_ADDR);
  assign nf_we_n  = !((ph_q == PH_LOW) && (kind_q != BK_READ));
  assign nf_re_n  = !((ph_q == PH_LOW) && (kind_q == BK_READ));
  assign nf_dq_oe = (ph_q != PH_IDLE) && (kind_q != BK_READ);
  assign nf_dq_o  = byte_q;

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale)); // R2
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_dq_oe && !nf_re_n)); // R13
endmodule

// File: rtl/nfc_busy_mon.sv
`timescale 1ns/1ps
module nfc_busy_mon #(
  parameter int WB_CYC   = 4,
  parameter int BUSY_MAX = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb,
  output logic ready,
  output logic timeout
);
  localparam int CW = $clog2(BUSY_MAX + 1);

  logic          act_q, act_d, rdy_q, rdy_d, to_q, to_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    rdy_d = 1'b0;
    to_d  = 1'b0;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if ((cnt_q >= CW'(WB_CYC)) && rb) begin
        rdy_d = 1'b1;
        act_d = 1'b0;
      end else if (cnt_q == CW'(BUSY_MAX)) begin
        to_d  = 1'b1;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      to_q  <= to_d;
    end
  end

  assign ready   = rdy_q;
  assign timeout = to_q;

  AST_READY_NEEDS_RB: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> $past(rb)); // R3
  AST_TIMEOUT_RB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> !$past(rb)); // R12
endmodule

// File: rtl/nand_cache_rd_seq.sv
`timescale 1ns/1ps
module nand_cache_rd_seq
  import nfc_pkg::*;
#(
  parameter int         COL_W      = 12,
  parameter int         ROW_W      = 17,
  parameter int         PAGE_BYTES = 2112,
  parameter int         MAIN_BYTES = 2048,
  parameter int         LAST_ROW   = (1 << ROW_W) - 1,
  parameter logic [7:0] EXIT_CMD   = 8'h3F,
  parameter int         STB_CYC    = 2,
  parameter int         WB_CYC     = 4,
  parameter int         BUSY_MAX   = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             out_spare,
  output logic             err_lastpage,
  output logic             err_timeout,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_rb
);
  localparam logic [COL_W-1:0] PG_END   = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_AT = COL_W'(MAIN_BYTES);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(LAST_ROW);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAITB, S_BUSY, S_RDGO, S_RDWAIT, S_OUT
  } st_e;

  st_e              st_q, st_d;
  nfc_op_e          op_q, op_d;
  logic [2:0]       step_q, step_d, last_step;
  logic [ROW_W-1:0] row_q, row_d, arow_q, arow_d;
  logic [COL_W-1:0] acol_q, acol_d, col_q, col_d;
  logic             run_q, run_d, cached_q, cached_d, errlp_q, errlp_d;
  logic             bus_go, bus_done, bm_start, bm_rdy, bm_to;
  bus_kind_e        bus_kind, scr_kind;
  logic [7:0]       bus_byte, scr_byte, bus_rbyte;
  logic [23:0]      row24;
  logic [15:0]      col16;

  assign row24 = 24'(arow_q);
  assign col16 = 16'(acol_q);

  // Byte script for the current request, indexed by step_q
  always_comb begin
    scr_kind = BK_ADDR;
    scr_byte = 8'h00;
    case (op_q)
      OP_START, OP_JUMP: begin
        last_step = 3'd6;
        case (step_q)
          3'd0: begin scr_kind = BK_CMD; scr_byte = CMD_PAGE_RD; end
          3'd3: scr_byte = row24[7:0];
          3'd4: scr_byte = row24[15:8];
          3'd5: scr_byte = row24[23:16];
          3'd6: begin
            scr_kind = BK_CMD;
            scr_byte = (op_q == OP_START) ? CMD_PAGE_GO : CMD_CACHE_GO;
          end
          default: scr_byte = 8'h00;
        endcase
      end
      OP_COLUMN: begin
        last_step = 3'd3;
        case (step_q)
          3'd0: begin scr_kind = BK_CMD; scr_byte = CMD_COL_SET; end
          3'd1: scr_byte = col16[7:0];
          3'd2: scr_byte = col16[15:8];
          default: begin scr_kind = BK_CMD; scr_byte = CMD_COL_GO; end
        endcase
      end
      default: begin
        last_step = 3'd0;
        scr_kind  = BK_CMD;
        scr_byte  = (op_q == OP_FINISH) ? EXIT_CMD : CMD_CACHE_GO;
      end
    endcase
  end

  always_comb begin
    st_d = st_q;  op_d = op_q;  step_d = step_q;
    row_d = row_q;  arow_d = arow_q;  acol_d = acol_q;  col_d = col_q;
    run_d = run_q;  cached_d = cached_q;  errlp_d = 1'b0;
    bus_go = 1'b0;  bus_kind = scr_kind;  bus_byte = scr_byte;  bm_start = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        case (nfc_op_e'(req_op))
          OP_START: if (!run_q) begin
            op_d = OP_START;  arow_d = req_row;  row_d = req_row;
            acol_d = '0;  run_d = 1'b1;  cached_d = 1'b0;
            step_d = '0;  st_d = S_ISSUE;
          end
          OP_NEXT: if (run_q) begin
            if (row_q == ROW_LAST) begin
              errlp_d = 1'b1;
            end else begin
              op_d = OP_NEXT;  row_d = row_q + 1'b1;  acol_d = '0;
              cached_d = 1'b1;  step_d = '0;  st_d = S_ISSUE;
            end
          end
          OP_JUMP: if (run_q) begin
            op_d = OP_JUMP;  arow_d = req_row;  row_d = req_row;  acol_d = '0;
            cached_d = 1'b1;  step_d = '0;  st_d = S_ISSUE;
          end
          OP_FINISH: if (run_q) begin
            op_d = OP_FINISH;  acol_d = '0;  run_d = 1'b0;
            cached_d = 1'b1;  step_d = '0;  st_d = S_ISSUE;
          end
          OP_COLUMN: if (run_q && cached_q) begin
            op_d = OP_COLUMN;  acol_d = req_col;  step_d = '0;  st_d = S_ISSUE;
          end
          default: ;
        endcase
      end
      S_ISSUE: begin
        bus_go = 1'b1;
        st_d   = S_WAITB;
      end
      S_WAITB: if (bus_done) begin
        if (step_q == last_step) begin
          if (op_q == OP_COLUMN) begin
            col_d = acol_q;
            st_d  = S_RDGO;
          end else begin
            bm_start = 1'b1;
            st_d     = S_BUSY;
          end
        end else begin
          step_d = step_q + 3'd1;
          st_d   = S_ISSUE;
        end
      end
      S_BUSY: if (bm_to) begin
        st_d = S_IDLE;  run_d = 1'b0;  cached_d = 1'b0;
      end else if (bm_rdy) begin
        if (op_q == OP_START) begin
          st_d = S_IDLE;
        end else begin
          col_d = acol_q;
          st_d  = S_RDGO;
        end
      end
      S_RDGO: begin
        bus_go   = 1'b1;
        bus_kind = BK_READ;
        st_d     = S_RDWAIT;
      end
      S_RDWAIT: if (bus_done) st_d = S_OUT;
      S_OUT: if (out_ready) begin
        if (col_q == PG_END) begin
          st_d = S_IDLE;
          if (op_q == OP_FINISH) cached_d = 1'b0;
        end else begin
          col_d = col_q + 1'b1;
          st_d  = S_RDGO;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  op_q <= OP_START;  step_q <= '0;
      row_q <= '0;  arow_q <= '0;  acol_q <= '0;  col_q <= '0;
      run_q <= 1'b0;  cached_q <= 1'b0;  errlp_q <= 1'b0;
    end else begin
      st_q <= st_d;  op_q <= op_d;  step_q <= step_d;
      row_q <= row_d;  arow_q <= arow_d;  acol_q <= acol_d;  col_q <= col_d;
      run_q <= run_d;  cached_q <= cached_d;  errlp_q <= errlp_d;
    end
  end

  nfc_bus_phy #(.STB_CYC(STB_CYC)) phy_i (
    .clk(clk), .rst_n(rst_n), .go(bus_go), .kind(bus_kind), .wbyte(bus_byte),
    .done(bus_done), .rbyte(bus_rbyte), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i)
  );

  nfc_busy_mon #(.WB_CYC(WB_CYC), .BUSY_MAX(BUSY_MAX)) bm_i (
    .clk(clk), .rst_n(rst_n), .start(bm_start), .rb(nf_rb),
    .ready(bm_rdy), .timeout(bm_to)
  );

  assign req_ready    = (st_q == S_IDLE);
  assign out_valid    = (st_q == S_OUT);
  assign out_data     = bus_rbyte;
  assign out_last     = (col_q == PG_END);
  assign out_spare    = (col_q >= SPARE_AT);
  assign err_lastpage = errlp_q;
  assign err_timeout  = bm_to;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11
  AST_STALL_RE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> nf_re_n); // R11
  AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cached_q); // R7
endmodule

// File: tb/nand_cache_rd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cache_rd_seq_tb_top;
  localparam int PB = 12;
  localparam int MB = 8;
  localparam int RW = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, out_valid, out_ready, out_last, out_spare;
  logic [2:0]    req_op;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic [7:0]    out_data, nf_dq_o, nf_dq_i;
  logic          err_lastpage, err_timeout, nf_cle, nf_ale, nf_we_n, nf_re_n;
  logic          nf_dq_oe, nf_rb;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  nand_cache_rd_seq #(
    .COL_W(CW), .ROW_W(RW), .PAGE_BYTES(PB), .MAIN_BYTES(MB),
    .EXIT_CMD(8'h3F), .STB_CYC(2), .WB_CYC(4), .BUSY_MAX(40)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_spare(out_spare), .err_lastpage(err_lastpage),
    .err_timeout(err_timeout), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  // Flash model: bus log, column tracking, ready/busy
  logic [7:0] log_b [64];
  logic       log_c [64];
  logic       log_a [64];
  int         log_n = 0;
  int         mcol = 0;
  int         acol = 0;
  int         acnt = 0;
  int         kick_n = 0;
  int         seen_n = 0;
  int         rd_falls = 0;
  int         viol = 0;
  int         ov_cnt = 0;
  int         lp_cnt = 0;
  int         to_cnt = 0;
  logic       hold_busy = 1'b0;

  assign nf_dq_i = 8'(mcol) ^ 8'hA5;

  always @(posedge nf_we_n) if (rst_n) begin
    if (log_n < 64) begin
      log_b[log_n] = nf_dq_o;
      log_c[log_n] = nf_cle;
      log_a[log_n] = nf_ale;
    end
    log_n++;
    if (nf_cle) begin
      case (nf_dq_o)
        8'h00, 8'h05: acnt = 0;
        8'h30, 8'h31, 8'h3F: begin mcol = 0; kick_n++; end
        8'hE0: mcol = acol;
        default: ;
      endcase
    end
    if (nf_ale) begin
      if (acnt == 0) acol = int'(nf_dq_o);
      if (acnt == 1) acol = acol + 256 * int'(nf_dq_o);
      acnt++;
    end
  end

  always @(posedge nf_re_n) if (rst_n) mcol++;
  always @(negedge nf_re_n) if (rst_n) begin
    rd_falls++;
    if (!nf_rb) viol++;
  end
  always @(negedge nf_we_n) if (rst_n && !nf_rb) viol++;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) ov_cnt++;
    if (err_lastpage) lp_cnt++;
    if (err_timeout) to_cnt++;
  end

  initial begin
    nf_rb = 1'b1;
    forever begin
      @(negedge clk);
      if (kick_n != seen_n) begin
        seen_n = kick_n;
        @(negedge clk);
        nf_rb = 1'b0;
        if (hold_busy) wait (!hold_busy);
        else repeat (10) @(negedge clk);
        @(negedge clk);
        nf_rb = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    log_n = 0; rd_falls = 0; ov_cnt = 0; lp_cnt = 0; to_cnt = 0;
  endtask

  task automatic send(input logic [2:0] op, input int row, input int col);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_row   = RW'(row);
    req_col   = CW'(col);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 500 && !req_ready; i++) @(negedge clk);
  endtask

  // exp entries: bit 8 set for a command byte, clear for an address byte
  task automatic chk_log(input string tag, input int n, input logic [8:0] exp [7]);
    chk(log_n == n, {tag, " cycle count"}, log_n, n);
    for (int i = 0; i < n && i < log_n; i++) begin
      chk(log_b[i] == exp[i][7:0], {tag, " byte"}, int'(log_b[i]), int'(exp[i][7:0]));
      chk(log_c[i] == exp[i][8] && log_a[i] == !exp[i][8], {tag, " CLE/ALE"},
          int'({log_c[i], log_a[i]}), int'({exp[i][8], !exp[i][8]}));
    end
  endtask

  task automatic collect(input int start, input bit stall, input string tag);
    int   got = 0;
    int   k = 0;
    int   ec = start;
    logic held_v = 1'b0;
    logic [7:0] held = '0;
    while (got < PB - start && k < 3000) begin
      @(negedge clk);
      k++;
      if (held_v) begin
        chk(out_valid && out_data == held && nf_re_n, "R11 stall hold",
            int'(out_data), int'(held));
      end
      out_ready = stall ? ((k % 3) != 0) : 1'b1;
      if (out_valid) begin
        if (out_ready) begin
          chk(out_data == (8'(ec) ^ 8'hA5), {tag, " R13 data"}, int'(out_data), int'(8'(ec) ^ 8'hA5));
          chk(out_last == (ec == PB - 1), "R4 last flag", int'(out_last), int'(ec == PB - 1));
          chk(out_spare == (ec >= MB), "R6 spare flag", int'(out_spare), int'(ec >= MB));
          ec++;
          got++;
          held_v = 1'b0;
        end else begin
          held_v = 1'b1;
          held   = out_data;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == PB - start, {tag, " byte count"}, got, PB - start);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_row = '0; req_col = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe, "R1 bus idle in reset",
        int'({nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}), 5'b11000);
    chk(!out_valid && req_ready, "R1 handshake in reset", int'({out_valid, req_ready}), 2'b01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !out_valid && req_ready, "R1 after release",
        int'({nf_we_n, nf_re_n, nf_cle, nf_ale, out_valid, req_ready}), 6'b110001);
  endtask

  task automatic t_start();
    clear_mon();
    send(3'd0, 5, 0);
    wait_idle();
    chk_log("R2 start", 7, '{9'h100, 9'h000, 9'h000, 9'h005, 9'h000, 9'h000, 9'h130});
    chk(rd_falls == 0 && ov_cnt == 0, "R7 no data after start", rd_falls + ov_cnt, 0);
  endtask

  task automatic t_col_early();
    clear_mon();
    send(3'd4, 3, 3);
    repeat (30) @(negedge clk);
    chk(log_n == 0 && rd_falls == 0 && ov_cnt == 0, "R7 early column ignored",
        log_n + rd_falls + ov_cnt, 0);
  endtask

  task automatic t_next();
    clear_mon();
    send(3'd1, 0, 0);
    collect(0, 1'b0, "R4 next");
    chk_log("R4 next", 1, '{9'h131, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0});
    wait_idle();
  endtask

  task automatic t_column();
    clear_mon();
    send(3'd4, 0, 5);
    collect(5, 1'b1, "R10 column");
    chk_log("R10 column", 4, '{9'h105, 9'h005, 9'h000, 9'h1E0, 9'h0, 9'h0, 9'h0});
    wait_idle();
  endtask

  task automatic t_jump(input int row);
    clear_mon();
    send(3'd2, row, 0);
    collect(0, 1'b1, "R5 jump");
    chk_log("R5 jump", 7, '{9'h100, 9'h000, 9'h000, 9'(row), 9'h000, 9'h000, 9'h131});
    wait_idle();
  endtask

  task automatic t_lastpage();
    clear_mon();
    send(3'd1, 0, 0);
    repeat (30) @(negedge clk);
    chk(lp_cnt == 1, "R9 error pulse", lp_cnt, 1);
    chk(log_n == 0 && rd_falls == 0, "R9 no bus cycle", log_n + rd_falls, 0);
  endtask

  task automatic t_finish();
    clear_mon();
    send(3'd3, 0, 0);
    collect(0, 1'b0, "R8 finish");
    chk_log("R8 finish", 1, '{9'h13F, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0});
    wait_idle();
    clear_mon();
    send(3'd1, 0, 0);
    repeat (30) @(negedge clk);
    chk(log_n == 0 && rd_falls == 0 && lp_cnt == 0, "R8 run closed",
        log_n + rd_falls + lp_cnt, 0);
  endtask

  task automatic t_timeout();
    hold_busy = 1'b1;
    clear_mon();
    send(3'd0, 1, 0);
    repeat (90) @(negedge clk);
    chk(to_cnt == 1, "R12 timeout pulse", to_cnt, 1);
    chk(req_ready == 1'b1, "R12 back to idle", int'(req_ready), 1);
    hold_busy = 1'b0;
    repeat (20) @(negedge clk);
    clear_mon();
    send(3'd1, 0, 0);
    repeat (30) @(negedge clk);
    chk(log_n == 0 && rd_falls == 0, "R12 run abandoned", log_n + rd_falls, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_start();
        t_col_early();
        t_next();
        t_column();
        t_jump(14);
        t_next();
        t_lastpage();
        t_jump(2);
        t_finish();
        t_timeout();
        chk(viol == 0, "R3 strobe while busy", viol, 0);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule